// File: doc/BRIEF.md
# Hardware Breakpoint Comparator Array

This block holds a parameterised bank of instruction breakpoint units, from 2 to 16 of them. Each unit keeps a value register and a control register, and both are loaded through a small write port that takes a unit index and a register select. In every cycle each enabled unit compares the current fetch against its own programmed condition. The condition can be an instruction address, the EL1 or EL2 context identifier, the current VMID, or the EL1 context identifier together with the VMID. A privilege mask in each unit limits its matches to user-level fetches, kernel-level fetches, or both.

An address unit can also be programmed as a linked unit. A linked unit hits only when its own address compare succeeds and a second unit, named by the link field, reports a context-class match in the same cycle. The block registers the per-unit hit vector and an OR of all hits, so a hit appears one cycle after the fetch that caused it. A constant output reports how many units are implemented.

The expected sequence is to write a unit's value register first and to set its enable bit afterwards.

Top module: `bkpt_cmp_array`

## Requirements
- R1: `num_units_o` always reports the parameter NUM_UNITS, which may be any value from 2 to 16.
- R2: A unit whose enable bit (control bit 0) is clear never hits. Reset clears every value and control register, so no unit hits after reset.
- R3: Type code 0 (plain address) hits when fetch address bits [VA_W-1:2] equal value bits [VA_W-1:2]. Address bits [1:0] take no part in the compare.
- R4: Type code 2 compares the EL1 context input with value bits [CTX_W-1:0]. Type code 3 compares the EL2 context input with the same value bits.
- R5: Type code 4 compares the VMID input with value bits [CTX_W+VMID_W-1:CTX_W]. Type code 5 hits only when the EL1 context equals value bits [CTX_W-1:0] and, in the same cycle, the VMID equals the upper VMID field.
- R6: Type code 1 (linked address) hits only when its address compare (as in R3) succeeds and the unit named in its link field (control bits [10:7]) is enabled, has a type of 2 to 5, and matches that type's compare in the same cycle. The linked target's privilege mask is not applied.
- R7: A linked unit whose link field names an unimplemented index (at least NUM_UNITS) or a unit whose type is not 2 to 5 never hits.
- R8: Control bits [2:1] are a privilege mask. Bit 1 permits a hit when `fetch_priv` is 0 (user level), and bit 2 permits a hit when `fetch_priv` is 1 (kernel level).
- R9: `hit_vec_o` and `any_hit_o` are registered. They show the result of the fetch presented in the previous cycle, they are zero when `fetch_vld` was low, and `any_hit_o` equals the OR of `hit_vec_o`.
- R10: A write with `wr_sel`=0 loads the value register and a write with `wr_sel`=1 loads the control register. A write takes effect for a fetch presented in the following cycle. A write whose index is NUM_UNITS or more changes no unit.
- R11: Type codes 6 to 15 never hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the value register, 1 selects the control register |
| wr_idx | input | 4 | Unit index for the write |
| wr_data | input | CTX_W+VMID_W | Write data; control uses bits [10:0] |
| fetch_vld | input | 1 | A fetch is presented this cycle |
| fetch_va | input | VA_W | Fetch virtual address |
| fetch_priv | input | 1 | 0 for user-level fetch, 1 for kernel-level fetch |
| ctx_el1 | input | CTX_W | Current EL1 context identifier |
| ctx_el2 | input | CTX_W | Current EL2 context identifier |
| vmid | input | VMID_W | Current VMID |
| hit_vec_o | output | NUM_UNITS | Registered per-unit hit flags |
| any_hit_o | output | 1 | Registered OR of all hits |
| num_units_o | output | 5 | Implemented unit count |

## Verification
The bench builds the block with NUM_UNITS=4 and the default widths (32-bit address and context, 16-bit VMID). With four units, indices 4 to 15 are legal in the 4-bit index and link fields but do not exist. Writes to those indices can therefore be checked for aliasing onto unit 0, and a link to a missing unit can be shown never to hit. Four units are also enough to hold an address, a context, a VMID/combined and a linked unit at once, so that the linked unit and its target can be watched hitting together.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // control register layout: link[10:7] kind[6:3] priv[2:1] en[0]
  typedef struct packed {
    logic [3:0] link;
    logic [3:0] kind;
    logic [1:0] priv;
    logic       en;
  } bkpt_ctrl_t;

  localparam int unsigned CTRL_W = $bits(bkpt_ctrl_t);

  localparam logic [3:0] KIND_ADDR     = 4'd0;
  localparam logic [3:0] KIND_ADDR_LNK = 4'd1;
  localparam logic [3:0] KIND_CTX1     = 4'd2;
  localparam logic [3:0] KIND_CTX2     = 4'd3;
  localparam logic [3:0] KIND_VMID     = 4'd4;
  localparam logic [3:0] KIND_CTX_VMID = 4'd5;

  // true for the kinds a linked address unit may point at
  function automatic logic is_ctx_kind(input logic [3:0] k);
    return (k >= KIND_CTX1) && (k <= KIND_CTX_VMID);
  endfunction

endpackage

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned IDX    = 0,
  parameter int unsigned VA_W   = 32,
  parameter int unsigned CTX_W  = 32,
  parameter int unsigned VMID_W = 16,
  localparam int unsigned VAL_W = CTX_W + VMID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [3:0]        wr_idx,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic [VA_W-1:0]   fetch_va,
  input  logic              fetch_priv,
  input  logic [CTX_W-1:0]  ctx_el1,
  input  logic [CTX_W-1:0]  ctx_el2,
  input  logic [VMID_W-1:0] vmid,
  output logic              en_o,
  output logic [3:0]        kind_o,
  output logic [3:0]        link_o,
  output logic              own_hit_o,
  output logic              lnk_addr_ok_o,
  output logic              ctx_ok_o
);

  logic [VAL_W-1:0] val_q;
  bkpt_ctrl_t       ctrl_q;
  logic             sel;

  assign sel = wr_en && (wr_idx == 4'(IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      ctrl_q <= '0;
    end else if (sel) begin
      if (wr_sel) ctrl_q <= bkpt_ctrl_t'(wr_data[CTRL_W-1:0]);
      else        val_q  <= wr_data;
    end
  end

  // word-aligned instruction address compare
  function automatic logic va_eq(input logic [VA_W-1:0] va, input logic [VAL_W-1:0] v);
    return va[VA_W-1:2] == v[VA_W-1:2];
  endfunction

  function automatic logic ctx_eq(input logic [CTX_W-1:0] c, input logic [VAL_W-1:0] v);
    return c == v[CTX_W-1:0];
  endfunction

  function automatic logic vmid_eq(input logic [VMID_W-1:0] m, input logic [VAL_W-1:0] v);
    return m == v[VAL_W-1:CTX_W];
  endfunction

  logic addr_m, c1_m, c2_m, vm_m, priv_ok;
  logic own_raw, ctx_raw;

  always_comb begin
    addr_m  = va_eq(fetch_va, val_q);
    c1_m    = ctx_eq(ctx_el1, val_q);
    c2_m    = ctx_eq(ctx_el2, val_q);
    vm_m    = vmid_eq(vmid, val_q);
    priv_ok = ctrl_q.priv[fetch_priv];
    ctx_raw = 1'b0;
    unique case (ctrl_q.kind)
      KIND_CTX1:     ctx_raw = c1_m;
      KIND_CTX2:     ctx_raw = c2_m;
      KIND_VMID:     ctx_raw = vm_m;
      KIND_CTX_VMID: ctx_raw = c1_m & vm_m;
      default:       ctx_raw = 1'b0;
    endcase
    own_raw = (ctrl_q.kind == KIND_ADDR) ? addr_m : ctx_raw;
  end

  assign en_o          = ctrl_q.en;
  assign kind_o        = ctrl_q.kind;
  assign link_o        = ctrl_q.link;
  assign own_hit_o     = ctrl_q.en & priv_ok & own_raw;
  assign ctx_ok_o      = ctrl_q.en & ctx_raw;
  assign lnk_addr_ok_o = ctrl_q.en & priv_ok & (ctrl_q.kind == KIND_ADDR_LNK) & addr_m;

  // R11: codes outside the defined set never produce a unit match
  p_unused_kind_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.kind > KIND_CTX_VMID) |-> !(own_hit_o || ctx_ok_o || lnk_addr_ok_o));

  // R8: a hit implies the privilege mask permits the current level
  p_priv_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_hit_o || lnk_addr_ok_o) |-> ctrl_q.priv[fetch_priv]);

endmodule

// File: rtl/bkpt_link_res.sv
module bkpt_link_res #(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic [NUM_UNITS-1:0]      ctx_ok,
  input  logic [NUM_UNITS-1:0][3:0] link_num,
  output logic [NUM_UNITS-1:0]      link_ok
);

  // pad to the full link space; missing units read as no match
  logic [15:0] ctx_pad;
  assign ctx_pad = 16'(ctx_ok);

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_res
    assign link_ok[i] = ctx_pad[link_num[i]];
  end

endmodule

// File: rtl/bkpt_hit_reg.sv
module bkpt_hit_reg #(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic [NUM_UNITS-1:0] hit_d,
  output logic [NUM_UNITS-1:0] hit_q,
  output logic                 any_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      any_q <= 1'b0;
    end else begin
      hit_q <= vld ? hit_d : '0;
      any_q <= vld & (|hit_d);
    end
  end

endmodule

// File: rtl/bkpt_cmp_array.sv
module bkpt_cmp_array
  import bkpt_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned VA_W      = 32,
  parameter int unsigned CTX_W     = 32,
  parameter int unsigned VMID_W    = 16,
  localparam int unsigned VAL_W    = CTX_W + VMID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [3:0]           wr_idx,
  input  logic [VAL_W-1:0]     wr_data,
  input  logic                 fetch_vld,
  input  logic [VA_W-1:0]      fetch_va,
  input  logic                 fetch_priv,
  input  logic [CTX_W-1:0]     ctx_el1,
  input  logic [CTX_W-1:0]     ctx_el2,
  input  logic [VMID_W-1:0]    vmid,
  output logic [NUM_UNITS-1:0] hit_vec_o,
  output logic                 any_hit_o,
  output logic [4:0]           num_units_o
);

  logic [NUM_UNITS-1:0]      en_vec, own_hit, lnk_addr_ok, ctx_ok, link_ok, hit_comb;
  logic [NUM_UNITS-1:0][3:0] kind_vec, link_vec;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    bkpt_unit #(
      .IDX(i), .VA_W(VA_W), .CTX_W(CTX_W), .VMID_W(VMID_W)
    ) u_unit (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
      .fetch_va(fetch_va), .fetch_priv(fetch_priv),
      .ctx_el1(ctx_el1), .ctx_el2(ctx_el2), .vmid(vmid),
      .en_o(en_vec[i]), .kind_o(kind_vec[i]), .link_o(link_vec[i]),
      .own_hit_o(own_hit[i]), .lnk_addr_ok_o(lnk_addr_ok[i]), .ctx_ok_o(ctx_ok[i])
    );
  end

  bkpt_link_res #(.NUM_UNITS(NUM_UNITS)) u_link (
    .ctx_ok(ctx_ok), .link_num(link_vec), .link_ok(link_ok)
  );

  assign hit_comb = own_hit | (lnk_addr_ok & link_ok);

  bkpt_hit_reg #(.NUM_UNITS(NUM_UNITS)) u_out (
    .clk(clk), .rst_n(rst_n), .vld(fetch_vld),
    .hit_d(hit_comb), .hit_q(hit_vec_o), .any_q(any_hit_o)
  );

  assign num_units_o = 5'(NUM_UNITS);

  // linked units whose target cannot ever satisfy them (observation only)
  logic [15:0][3:0]     kind_pad;
  logic [NUM_UNITS-1:0] bad_link;
  always_comb begin
    kind_pad = '0;
    for (int k = 0; k < NUM_UNITS; k++) kind_pad[k] = kind_vec[k];
    for (int k = 0; k < NUM_UNITS; k++)
      bad_link[k] = (kind_vec[k] == KIND_ADDR_LNK) &&
                    ((32'(link_vec[k]) >= NUM_UNITS) || !is_ctx_kind(kind_pad[link_vec[k]]));
  end

  // R2: a registered hit needs the unit enabled in the fetch cycle
  p_hit_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec_o & ~$past(en_vec)) == '0);

  // R9: no hit without a valid fetch one cycle earlier
  p_hit_needs_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec_o) |-> $past(fetch_vld));

  // R9: combined flag agrees with the vector
  p_any_agrees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit_o == (|hit_vec_o));

  // R7: a broken link never yields a hit
  p_bad_link_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec_o & $past(bad_link)) == '0);

  // R10: writes aimed beyond the bank leave every enable untouched
  p_oob_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_idx) >= NUM_UNITS)) |=> $stable(en_vec));

endmodule

// File: tb/sim_bkpt_cmp_array.sv
module sim_bkpt_cmp_array;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [47:0] wr_data = '0;
  logic        fetch_vld = 1'b0, fetch_priv = 1'b0;
  logic [31:0] fetch_va = '0, ctx_el1 = '0, ctx_el2 = '0;
  logic [15:0] vmid = '0;
  logic [N-1:0] hit_vec_o;
  logic        any_hit_o;
  logic [4:0]  num_units_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  bkpt_cmp_array #(.NUM_UNITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .fetch_vld(fetch_vld), .fetch_va(fetch_va),
    .fetch_priv(fetch_priv), .ctx_el1(ctx_el1), .ctx_el2(ctx_el2), .vmid(vmid),
    .hit_vec_o(hit_vec_o), .any_hit_o(any_hit_o), .num_units_o(num_units_o)
  );

  // scoreboard queues
  logic [N-1:0] q_exp[$];
  string        q_req[$];

  function automatic logic [47:0] mk_ctrl(input bit en, input logic [1:0] pr,
                                          input logic [3:0] kind, input logic [3:0] lnk);
    return 48'({lnk, kind, pr, en});
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expectation per registered result
  always @(posedge clk) begin
    if (rst_n && q_exp.size() > 0) begin
      logic [N-1:0] e;
      string r;
      #2;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      check({r, " hit_vec"}, 32'(hit_vec_o), 32'(e));
      check({r, " any_hit"}, 32'(any_hit_o), 32'(|e));
    end
  end

  task automatic wr(input bit sel, input logic [3:0] idx, input logic [47:0] d);
    @(negedge clk);
    fetch_vld = 1'b0;
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fetch(input bit vld, input logic [31:0] va, input bit pr,
                       input logic [31:0] c1, input logic [31:0] c2, input logic [15:0] vm,
                       input logic [N-1:0] exp, input string req);
    @(negedge clk);
    fetch_vld = vld; fetch_va = va; fetch_priv = pr;
    ctx_el1 = c1; ctx_el2 = c2; vmid = vm;
    q_exp.push_back(exp);
    q_req.push_back(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset hit_vec", 32'(hit_vec_o), 0);
    check("R2 reset any_hit", 32'(any_hit_o), 0);
    check("R1 unit count", 32'(num_units_o), N);
    @(negedge clk); rst_n = 1'b1;
    fetch(1, 32'h1000, 1, 0, 0, 0, 4'b0000, "R2 after reset no hits");

    // R3 plain address on unit 0
    wr(0, 0, 48'h1000);
    wr(1, 0, mk_ctrl(1, 2'b11, 4'd0, 0));
    fetch(1, 32'h1000, 1, 0, 0, 0, 4'b0001, "R3 exact address");
    fetch(1, 32'h1003, 1, 0, 0, 0, 4'b0001, "R3 low bits ignored");
    fetch(1, 32'h1004, 1, 0, 0, 0, 4'b0000, "R3 next word");
    fetch(0, 32'h1000, 1, 0, 0, 0, 4'b0000, "R9 invalid fetch");

    // R8 privilege mask: user only
    wr(1, 0, mk_ctrl(1, 2'b01, 4'd0, 0));
    fetch(1, 32'h1000, 1, 0, 0, 0, 4'b0000, "R8 kernel filtered");
    fetch(1, 32'h1000, 0, 0, 0, 0, 4'b0001, "R8 user allowed");
    wr(1, 0, mk_ctrl(1, 2'b11, 4'd0, 0));

    // R4 context units on unit 1
    wr(0, 1, 48'hAAAA_0001);
    wr(1, 1, mk_ctrl(1, 2'b11, 4'd2, 0));
    fetch(1, 32'h9000, 1, 32'hAAAA_0001, 32'h5, 0, 4'b0010, "R4 EL1 context");
    wr(1, 1, mk_ctrl(1, 2'b11, 4'd3, 0));
    fetch(1, 32'h9000, 1, 32'hAAAA_0001, 32'h5, 0, 4'b0000, "R4 EL2 selected, EL1 ignored");
    fetch(1, 32'h9000, 1, 32'h5, 32'hAAAA_0001, 0, 4'b0010, "R4 EL2 context");

    // R5 VMID and combined on unit 2
    wr(0, 2, 48'h0055_0000_0000);
    wr(1, 2, mk_ctrl(1, 2'b11, 4'd4, 0));
    fetch(1, 32'h9000, 1, 0, 0, 16'h55, 4'b0100, "R5 VMID");
    wr(0, 2, 48'h0055_1234_5678);
    wr(1, 2, mk_ctrl(1, 2'b11, 4'd5, 0));
    fetch(1, 32'h9000, 1, 32'h1234_5678, 0, 16'h55, 4'b0100, "R5 context and VMID");
    fetch(1, 32'h9000, 1, 32'h1234_5679, 0, 16'h55, 4'b0000, "R5 context mismatch");
    fetch(1, 32'h9000, 1, 32'h1234_5678, 0, 16'h56, 4'b0000, "R5 VMID mismatch");

    // R6 linked address on unit 3 -> unit 2
    wr(0, 3, 48'h2000);
    wr(1, 3, mk_ctrl(1, 2'b11, 4'd1, 4'd2));
    fetch(1, 32'h2000, 1, 32'h1234_5678, 0, 16'h55, 4'b1100, "R6 linked both match");
    fetch(1, 32'h2000, 1, 32'h0, 0, 16'h55, 4'b0000, "R6 linked target miss");
    fetch(1, 32'h2004, 1, 32'h1234_5678, 0, 16'h55, 4'b0100, "R6 linked address miss");
    wr(1, 2, mk_ctrl(0, 2'b11, 4'd5, 0));
    fetch(1, 32'h2000, 1, 32'h1234_5678, 0, 16'h55, 4'b0000, "R6 linked target disabled");
    wr(1, 2, mk_ctrl(1, 2'b00, 4'd5, 0));
    fetch(1, 32'h2000, 1, 32'h1234_5678, 0, 16'h55, 4'b1000, "R6 target privilege not applied");
    wr(1, 2, mk_ctrl(1, 2'b11, 4'd5, 0));

    // R7 broken links
    wr(1, 3, mk_ctrl(1, 2'b11, 4'd1, 4'd5));
    fetch(1, 32'h2000, 1, 32'h1234_5678, 0, 16'h55, 4'b0100, "R7 link to missing unit");
    wr(0, 0, 48'h2000);
    wr(1, 3, mk_ctrl(1, 2'b11, 4'd1, 4'd0));
    fetch(1, 32'h2000, 1, 32'h1234_5678, 0, 16'h55, 4'b0101, "R7 link to address unit");

    // R11 unused kind
    wr(0, 0, 48'h1000);
    wr(1, 0, mk_ctrl(1, 2'b11, 4'd6, 0));
    fetch(1, 32'h1000, 1, 32'h1000, 32'h1000, 16'h0, 4'b0000, "R11 kind 6 quiet");
    wr(1, 0, mk_ctrl(1, 2'b11, 4'd15, 0));
    fetch(1, 32'h1000, 1, 32'h1000, 32'h1000, 16'h0, 4'b0000, "R11 kind 15 quiet");

    // R2 disabled unit
    wr(1, 0, mk_ctrl(0, 2'b11, 4'd0, 0));
    fetch(1, 32'h1000, 1, 0, 0, 0, 4'b0000, "R2 disabled address unit");

    // R10 out-of-range writes and write timing
    wr(1, 4, mk_ctrl(1, 2'b11, 4'd0, 0));
    fetch(1, 32'h1000, 1, 0, 0, 0, 4'b0000, "R10 control write to idx 4 ignored");
    wr(0, 4, 48'h3000);
    wr(1, 0, mk_ctrl(1, 2'b11, 4'd0, 0));
    fetch(1, 32'h1000, 1, 0, 0, 0, 4'b0001, "R10 value write to idx 4 ignored");
    fetch(1, 32'h3000, 1, 0, 0, 0, 4'b0000, "R10 no alias onto unit 0");
    wr(0, 0, 48'h4000);
    fetch(1, 32'h4000, 1, 0, 0, 0, 4'b0001, "R10 new value used next cycle");

    @(negedge clk); fetch_vld = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 unit count end", 32'(num_units_o), N);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule